// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block collects the fault inputs that can force the outputs of a PWM channel pair into a safe state. It takes two analog comparator outputs, two external brake pins, an ADC result monitor, a system-failure input and a per-pair software request. Each brake pin first passes through an optional inversion and then a noise filter. The filter is clocked by a prescaled sample tick and lets a new level through only after that level has persisted for a programmed number of samples.

Each pair has its own enable vectors, one for edge-type brakes and one for level-type brakes. An edge-type brake latches and holds until software clears it. A level-type brake follows its sources and releases only at the start of a new PWM period once every enabled level source has gone quiet. The `brake_o` bit of a pair is the OR of both kinds and overrides the pair's PWM outputs downstream. Sticky edge and level interrupt flags are kept separately.

Comparator and pin faults can be suppressed by a leading-edge blanking window. The window opens after a selected edge of any chosen even PWM channel and lasts a programmed number of clocks.

Top module: `fault_brake_ctrl`

## Requirements
- R1: After reset, `brake_o`, `edge_flag_o` and `level_flag_o` are all zero.
- R2: Source enable bits for pair p sit at bits `p*6+s` of `edge_en_i` and `level_en_i`, in this order: s=0 comparator 0, s=1 comparator 1, s=2 pin 0, s=3 pin 1, s=4 ADC monitor, s=5 system fail. A source whose bit is clear has no effect on that pair.
- R3: An active edge-enabled source sets the pair's edge latch (`brake_o` and `edge_flag_o`) one clock later. The latch holds after the source goes inactive until `edge_clr_i[p]` is sampled high. A new fault in the same cycle as the clear wins.
- R4: An active level-enabled source sets the pair's level brake and `level_flag_o` one clock later. The level brake holds until `prd_start_i[p]` is sampled while no level source of the pair is active. `level_flag_o` holds until `level_clr_i[p]`.
- R5: `sw_brk_i` bit p requests an edge-type brake for pair p, and bit 8+p requests a level-type brake for pair p.
- R6: When `pin_inv_i[k]` is 1, brake pin k is active low; otherwise it is active high.
- R7: With the filter on, sample ticks come every 2^`flt_div_i` clocks. The filtered pin takes a new level after `flt_cnt_i` consecutive ticks that see that level, and a value of 0 counts as 1. A pulse that spans fewer ticks is rejected. With the filter off, the pin is registered once.
- R8: `leb_type_i` 0 selects rising edges, 1 falling, 2 either and 3 none, on the even channels enabled in `leb_sel_i`. After such an edge, comparator and pin faults are ignored for the next `leb_len_i` clocks.
- R9: The ADC monitor, system-fail and software requests are never blanked.
- R10: `brake_o[p]` is the OR of the pair's edge and level latches. Comparator, ADC, system and software faults reach it after 1 clock, and a pin with the filter off after 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2 | Comparator fault inputs, active high |
| pin_i | input | 2 | External brake pins |
| pin_inv_i | input | 2 | Per-pin inversion |
| adc_mon_i | input | 1 | ADC result monitor fault |
| sys_fail_i | input | 1 | System failure fault |
| flt_en_i | input | 1 | Pin noise filter enable |
| flt_div_i | input | 3 | Sample tick divider exponent |
| flt_cnt_i | input | 4 | Required stable sample count |
| edge_en_i | input | 18 | Edge-type source enables, 6 per pair |
| level_en_i | input | 18 | Level-type source enables, 6 per pair |
| sw_brk_i | input | 16 | Software brake requests (edge at bit p, level at 8+p) |
| edge_clr_i | input | 3 | Clear edge latch and flag per pair |
| level_clr_i | input | 3 | Clear level flag per pair |
| prd_start_i | input | 3 | PWM period start pulse per pair |
| pwm_even_i | input | 3 | Even PWM channel levels (0, 2, 4) |
| leb_sel_i | input | 3 | Even channels that trigger blanking |
| leb_type_i | input | 2 | Blanking trigger edge type |
| leb_len_i | input | 8 | Blanking window length in clocks |
| brake_o | output | 3 | Brake active per pair |
| edge_flag_o | output | 3 | Edge brake interrupt flag per pair |
| level_flag_o | output | 3 | Level brake interrupt flag per pair |

## Verification
Direct faults (comparator, ADC, system, software) are due at `brake_o` one clock after the edge that samples them. Filter-off pin faults are due after two clocks. The bench drives on falling edges and samples on the next falling edge, so each check sits exactly one or two rising edges after its stimulus. The filtered delay depends on where the free-running tick falls, so the sweep over divider and count accepts the first assertion anywhere between (N-1)·2^d+2 and N·2^d+1 clocks and fails anything earlier or later. Blanking is probed in the last blanked clock and in the first clock after it, with the trigger edge counted as the rising edge that loads the window.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned NSRC    = 6;
  localparam int unsigned SRC_C0  = 0;
  localparam int unsigned SRC_C1  = 1;
  localparam int unsigned SRC_P0  = 2;
  localparam int unsigned SRC_P1  = 3;
  localparam int unsigned SRC_ADC = 4;
  localparam int unsigned SRC_SYS = 5;
  localparam int unsigned SW_LVL_OFS = 8;

  typedef enum logic [1:0] {
    LEB_RISE = 2'd0,
    LEB_FALL = 2'd1,
    LEB_BOTH = 2'd2,
    LEB_NONE = 2'd3
  } leb_type_e;
endpackage

// File: rtl/fb_pin_filter.sv
module fb_pin_filter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_lim_i,
  input  logic          d_i,
  output logic          q_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   lim, nxt;

  assign lim = (cnt_lim_i == '0) ? (CW+1)'(1) : {1'b0, cnt_lim_i};
  assign nxt = {1'b0, cnt_q} + (CW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      q_o   <= d_i;
      cnt_q <= '0;
    end else if (d_i == q_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (nxt >= lim) begin
        q_o   <= d_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= nxt[CW-1:0];
      end
    end
  end

  // R7
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(q_o));
endmodule

// File: rtl/fb_blanker.sv
module fb_blanker
  import fb_pkg::*;
#(
  parameter int unsigned NE = 3,
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NE-1:0] pwm_i,
  input  logic [NE-1:0] sel_i,
  input  logic [1:0]    type_i,
  input  logic [LW-1:0] len_i,
  output logic          blank_o
);
  logic [NE-1:0] prev_q, ev;
  logic [LW-1:0] cnt_q;
  logic          trig;

  always_comb begin
    unique case (leb_type_e'(type_i))
      LEB_RISE: ev = pwm_i & ~prev_q;
      LEB_FALL: ev = ~pwm_i & prev_q;
      LEB_BOTH: ev = pwm_i ^ prev_q;
      default:  ev = '0;
    endcase
  end

  assign trig    = |(ev & sel_i);
  assign blank_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= pwm_i;
      if (trig)          cnt_q <= len_i;
      else if (blank_o)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  blank_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && len_i != '0) |=> blank_o);
endmodule

// File: rtl/fb_pair_latch.sv
module fb_pair_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_hit_i,
  input  logic lvl_hit_i,
  input  logic edge_clr_i,
  input  logic lvl_clr_i,
  input  logic prd_start_i,
  output logic brake_o,
  output logic edge_flag_o,
  output logic lvl_flag_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_flag_o <= 1'b0;
      lvl_q       <= 1'b0;
      lvl_flag_o  <= 1'b0;
    end else begin
      if (edge_hit_i)      edge_flag_o <= 1'b1;
      else if (edge_clr_i) edge_flag_o <= 1'b0;
      if (lvl_hit_i)        lvl_q <= 1'b1;
      else if (prd_start_i) lvl_q <= 1'b0;
      if (lvl_hit_i)       lvl_flag_o <= 1'b1;
      else if (lvl_clr_i)  lvl_flag_o <= 1'b0;
    end
  end

  assign brake_o = edge_flag_o | lvl_q;

  // R3
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_flag_o && !edge_clr_i) |=> edge_flag_o);
  // R4
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q && !prd_start_i) |=> brake_o);
  // R4
  lvl_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_hit_i |=> lvl_flag_o);
endmodule

// File: rtl/fault_brake_ctrl.sv
module fault_brake_ctrl
  import fb_pkg::*;
#(
  parameter int unsigned NPAIR = 3,
  parameter int unsigned FCW   = 4,
  parameter int unsigned LW    = 8,
  parameter int unsigned SWW   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            cmp_i,
  input  logic [1:0]            pin_i,
  input  logic [1:0]            pin_inv_i,
  input  logic                  adc_mon_i,
  input  logic                  sys_fail_i,
  input  logic                  flt_en_i,
  input  logic [2:0]            flt_div_i,
  input  logic [FCW-1:0]        flt_cnt_i,
  input  logic [NPAIR*NSRC-1:0] edge_en_i,
  input  logic [NPAIR*NSRC-1:0] level_en_i,
  input  logic [SWW-1:0]        sw_brk_i,
  input  logic [NPAIR-1:0]      edge_clr_i,
  input  logic [NPAIR-1:0]      level_clr_i,
  input  logic [NPAIR-1:0]      prd_start_i,
  input  logic [NPAIR-1:0]      pwm_even_i,
  input  logic [NPAIR-1:0]      leb_sel_i,
  input  logic [1:0]            leb_type_i,
  input  logic [LW-1:0]         leb_len_i,
  output logic [NPAIR-1:0]      brake_o,
  output logic [NPAIR-1:0]      edge_flag_o,
  output logic [NPAIR-1:0]      level_flag_o
);
  localparam int unsigned PSW = 7;

  logic [PSW-1:0]  presc_q, presc_mask;
  logic            tick;
  logic [1:0]      pin_filt;
  logic            blank;
  logic [NSRC-1:0] src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) presc_q <= '0;
    else         presc_q <= presc_q + 1'b1;
  end
  assign presc_mask = (PSW'(1) << flt_div_i) - PSW'(1);
  assign tick       = ((presc_q & presc_mask) == '0);

  for (genvar k = 0; k < 2; k++) begin : g_pin
    fb_pin_filter #(.CW(FCW)) u_filt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (flt_en_i),
      .tick_i    (tick),
      .cnt_lim_i (flt_cnt_i),
      .d_i       (pin_i[k] ^ pin_inv_i[k]),
      .q_o       (pin_filt[k])
    );
  end

  fb_blanker #(.NE(NPAIR), .LW(LW)) u_leb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwm_i   (pwm_even_i),
    .sel_i   (leb_sel_i),
    .type_i  (leb_type_i),
    .len_i   (leb_len_i),
    .blank_o (blank)
  );

  always_comb begin
    src          = '0;
    src[SRC_C0]  = cmp_i[0]    & ~blank;
    src[SRC_C1]  = cmp_i[1]    & ~blank;
    src[SRC_P0]  = pin_filt[0] & ~blank;
    src[SRC_P1]  = pin_filt[1] & ~blank;
    src[SRC_ADC] = adc_mon_i;
    src[SRC_SYS] = sys_fail_i;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic edge_hit, lvl_hit;
    assign edge_hit = (|(src & edge_en_i[p*NSRC +: NSRC]))  | sw_brk_i[p];
    assign lvl_hit  = (|(src & level_en_i[p*NSRC +: NSRC])) | sw_brk_i[SW_LVL_OFS+p];

    fb_pair_latch u_latch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .edge_hit_i  (edge_hit),
      .lvl_hit_i   (lvl_hit),
      .edge_clr_i  (edge_clr_i[p]),
      .lvl_clr_i   (level_clr_i[p]),
      .prd_start_i (prd_start_i[p]),
      .brake_o     (brake_o[p]),
      .edge_flag_o (edge_flag_o[p]),
      .lvl_flag_o  (level_flag_o[p])
    );

    // R5
    sw_brake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_brk_i[p] || sw_brk_i[SW_LVL_OFS+p]) |=> brake_o[p]);
    // R9
    unblanked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((adc_mon_i && edge_en_i[p*NSRC+SRC_ADC]) ||
       (sys_fail_i && edge_en_i[p*NSRC+SRC_SYS])) |=> edge_flag_o[p]);
  end
endmodule

// File: tb/fault_brake_ctrl_test.sv
module fault_brake_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cmp_i = '0, pin_i = '0, pin_inv_i = '0;
  logic        adc_mon_i = 1'b0, sys_fail_i = 1'b0, flt_en_i = 1'b0;
  logic [2:0]  flt_div_i = '0;
  logic [3:0]  flt_cnt_i = '0;
  logic [17:0] edge_en_i = '0, level_en_i = '0;
  logic [15:0] sw_brk_i = '0;
  logic [2:0]  edge_clr_i = '0, level_clr_i = '0, prd_start_i = '0;
  logic [2:0]  pwm_even_i = '0, leb_sel_i = '0;
  logic [1:0]  leb_type_i = '0;
  logic [7:0]  leb_len_i = '0;
  logic [2:0]  brake_o, edge_flag_o, level_flag_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_brake_ctrl uut (.*, .clk_i(clk));

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_all();
    edge_clr_i = '1; level_clr_i = '1; prd_start_i = '1;
    step(1);
    edge_clr_i = '0; level_clr_i = '0; prd_start_i = '0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 brake", brake_o, 0);
    chk("R1 edge flag", edge_flag_o, 0);
    chk("R1 level flag", level_flag_o, 0);
    rst_ni = 1'b1;
    step(1);

    // R3 / R2: comparator 0 edge-enabled on pair 0 only
    edge_en_i[0] = 1'b1;
    cmp_i[0] = 1'b1; step(1); cmp_i[0] = 1'b0;
    chk("R3 latch", brake_o, 3'b001);
    chk("R2 other pairs", edge_flag_o, 3'b001);
    step(5);
    chk("R3 hold", brake_o, 3'b001);
    edge_clr_i[0] = 1'b1; step(1); edge_clr_i[0] = 1'b0;
    chk("R3 clear", {brake_o, edge_flag_o}, 0);
    cmp_i[0] = 1'b1; edge_clr_i[0] = 1'b1; step(1);
    cmp_i[0] = 1'b0; edge_clr_i[0] = 1'b0;
    chk("R3 set wins", edge_flag_o, 3'b001);
    clr_all();
    edge_en_i = '0;

    // R4: ADC monitor level-enabled on pair 1
    level_en_i[1*6+4] = 1'b1;
    adc_mon_i = 1'b1; step(1);
    chk("R4 set", {brake_o, level_flag_o}, {3'b010, 3'b010});
    prd_start_i[1] = 1'b1; step(1); prd_start_i[1] = 1'b0;
    chk("R4 active at period", brake_o, 3'b010);
    adc_mon_i = 1'b0; step(3);
    chk("R4 wait period", brake_o, 3'b010);
    prd_start_i[1] = 1'b1; step(1); prd_start_i[1] = 1'b0;
    chk("R4 release", brake_o, 3'b000);
    chk("R4 flag sticky", level_flag_o, 3'b010);
    level_clr_i[1] = 1'b1; step(1); level_clr_i[1] = 1'b0;
    chk("R4 flag clear", level_flag_o, 3'b000);
    level_en_i = '0;

    // R5: software requests
    sw_brk_i[2] = 1'b1; step(1); sw_brk_i[2] = 1'b0;
    chk("R5 edge bit", {brake_o, edge_flag_o, level_flag_o}, {3'b100, 3'b100, 3'b000});
    clr_all();
    sw_brk_i[8] = 1'b1; step(1);
    chk("R5 level bit", {brake_o, edge_flag_o, level_flag_o}, {3'b001, 3'b000, 3'b001});
    sw_brk_i[8] = 1'b0; prd_start_i[0] = 1'b1; step(1); prd_start_i[0] = 1'b0;
    chk("R5 level release", brake_o, 3'b000);
    clr_all();

    // R10: filter off, pin 0 on pair 0
    edge_en_i[2] = 1'b1;
    pin_i[0] = 1'b1; step(1);
    chk("R10 pin first clock", brake_o, 3'b000);
    step(1);
    chk("R10 pin second clock", brake_o, 3'b001);
    pin_i[0] = 1'b0; step(3); clr_all();

    // R6: pin 1 inverted on pair 1
    edge_en_i[1*6+3] = 1'b1;
    pin_inv_i[1] = 1'b1; pin_i[1] = 1'b1; step(4);
    chk("R6 inverted idle", brake_o, 3'b000);
    pin_i[1] = 1'b0; step(2);
    chk("R6 inverted fault", brake_o, 3'b010);
    pin_i[1] = 1'b1; step(3); clr_all();
    edge_en_i = '0; edge_en_i[2] = 1'b1;

    // R7: filter sweep over divider and count
    flt_en_i = 1'b1;
    for (int d = 0; d < 3; d++) begin
      for (int n = 1; n < 4; n++) begin
        int p, c;
        p = 1 << d;
        flt_div_i = 3'(d); flt_cnt_i = 4'(n);
        step(2);
        pin_i[0] = 1'b1;
        c = 0;
        for (int i = 1; i <= 64; i++) begin
          step(1);
          if (brake_o[0]) begin c = i; break; end
        end
        chk($sformatf("R7 delay low d=%0d n=%0d", d, n), 32'(c >= (n-1)*p+2), 1);
        chk($sformatf("R7 delay high d=%0d n=%0d", d, n), 32'(c <= n*p+1), 1);
        pin_i[0] = 1'b0; step(n*p+4); clr_all();
        if (n >= 2) begin
          pin_i[0] = 1'b1; step(1); pin_i[0] = 1'b0;
          step(20);
          chk($sformatf("R7 glitch d=%0d n=%0d", d, n), brake_o, 3'b000);
        end
      end
    end
    flt_cnt_i = 4'd0; flt_div_i = 3'd0; step(1);
    pin_i[0] = 1'b1; step(2);
    chk("R7 zero count as one", brake_o, 3'b001);
    pin_i[0] = 1'b0; step(4); clr_all();
    flt_en_i = 1'b0; edge_en_i = '0;

    // R8 / R9: blanking on channel 0 rising, len 5
    edge_en_i[1] = 1'b1; edge_en_i[2*6+5] = 1'b1;
    leb_sel_i = 3'b001; leb_type_i = 2'd0; leb_len_i = 8'd5;
    pwm_even_i[0] = 1'b1; step(1);
    cmp_i[1] = 1'b1; sys_fail_i = 1'b1; step(1);
    cmp_i[1] = 1'b0; sys_fail_i = 1'b0;
    chk("R8 cmp blanked", brake_o[0], 0);
    chk("R9 sys not blanked", brake_o[2], 1);
    step(3);
    cmp_i[1] = 1'b1; step(1); cmp_i[1] = 1'b0;
    chk("R8 last blanked clock", brake_o[0], 0);
    cmp_i[1] = 1'b1; step(1); cmp_i[1] = 1'b0;
    chk("R8 after window", brake_o[0], 1);
    clr_all();
    leb_type_i = 2'd1;
    pwm_even_i[0] = 1'b0; step(1);
    cmp_i[1] = 1'b1; step(1); cmp_i[1] = 1'b0;
    chk("R8 falling blanks", brake_o[0], 0);
    step(6);
    pwm_even_i[0] = 1'b1; step(1);
    cmp_i[1] = 1'b1; step(1); cmp_i[1] = 1'b0;
    chk("R8 rising ignored in falling mode", brake_o[0], 1);
    clr_all();
    leb_type_i = 2'd2;
    pwm_even_i[0] = 1'b0; step(1);
    edge_en_i = '0; edge_en_i[4] = 1'b1; edge_en_i[2*6+4] = 1'b1; edge_en_i[0] = 1'b1;
    adc_mon_i = 1'b1; cmp_i[0] = 1'b1; step(1);
    adc_mon_i = 1'b0; cmp_i[0] = 1'b0;
    chk("R9 adc not blanked", brake_o, 3'b101);
    step(1); clr_all();
    chk("R8 either clears", brake_o, 3'b000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule